// File: doc/BRIEF.md
# Coprocessor Wakeup Timer Sequencer

This block decides when a small low-power coprocessor core is allowed to run. A run command sets the timer enable and records the entry address. The block then powers the core up through a fixed wake phase and a fixed clock-settle phase. At the end it issues a one-cycle start pulse together with the recorded start address.

When the core later reports a halt, the block spends a fixed number of cycles preparing for sleep. It then counts up toward one of five programmable period registers and, when the count is reached, goes through wake and settle again. In this way the program is restarted periodically for as long as the timer enable stays set.

The program running on the core can choose which period register later wakeups use, and it can turn the timer off. Turning the timer off does not stop the current pass: the core runs on to its halt, and no further restarts happen until a new run command arrives. While the system is in deep sleep, a period-select request is overridden and index 0 is used.

Top module: `cop_wake_sequencer`

## Requirements
- R1: After reset the block is idle with `busy`, `coreStart` and `cfgErr` low, the timer disabled, and period index 0 selected for counting.
- R2: A `runReq` while idle records `runEntry` and sets the timer enable. `coreStart` is then high in the 18th cycle after the sampling edge (2 wake cycles plus 16 settle cycles), with `startPc` equal to the recorded entry.
- R3: A `haltPulse` sampled while the core runs is followed by 2 sleep-preparation cycles, then P+1 counting cycles (P being the selected period), then wake and settle. `coreStart` is therefore high in cycle P+21 after the halt edge.
- R4: A `selReq` with `selIdx` from 0 to 4 selects that period register for later counts. A `selReq` with `selIdx` of 5 or above leaves the selection unchanged.
- R5: A `selReq` sampled while `deepSleep` is high selects index 0, whatever `selIdx` holds.
- R6: A `cfgWrEn` with `cfgWrIdx` from 0 to 4 loads `cfgWrData` into that period register. With `cfgWrIdx` of 5 or above, no period changes and `cfgErr` is high for exactly the next cycle.
- R7: A `timerOffReq` clears the timer enable while the current program keeps running (`busy` stays high). After its halt and the preparation cycles the block returns to idle, with no `coreStart` and `busy` low. A new `runReq` restarts it.
- R8: A `runReq` sampled while the block is not idle does not disturb the running sequence. It replaces the entry used by the following restarts.
- R9: The count restarts from zero on every entry to counting and ends once it is greater than or equal to the selected period. Lowering that period below the current count ends counting in the following cycle.
- R10: `busy` is high during wake, settle, run and sleep preparation, and low while idle or counting.
- R11: `coreStart` is a single-cycle pulse and is followed by the run phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Period register write strobe |
| cfgWrIdx | input | IDX_W | Period register index for the write |
| cfgWrData | input | PERIOD_W | Period value in cycles |
| runReq | input | 1 | Run command: enable timer and record entry |
| runEntry | input | PC_W | Entry address for the run command |
| haltPulse | input | 1 | Core reports that its program halted |
| selReq | input | 1 | Period-select command from the program |
| selIdx | input | IDX_W | Requested period register index |
| timerOffReq | input | 1 | Clear the timer enable |
| deepSleep | input | 1 | System is in deep sleep |
| coreStart | output | 1 | One-cycle start pulse to the core |
| startPc | output | PC_W | Address where the core starts |
| busy | output | 1 | Core powered: wake, settle, run or prepare phase |
| cfgErr | output | 1 | One-cycle flag for a write to a missing period index |

## Verification
The halt-to-start latency is measured against six different period selections. These include a zero period, the longest programmed period, a selection forced to zero by deep sleep, and an out-of-range index that must leave the previous choice in place. Because every programmed period is distinct, each latency shows exactly which register was used. Further directed runs cover the fixed 18-cycle start-up and replacing the entry address in mid-run. They also cover lowering a period while counting is under way, which separates a greater-or-equal compare from an equality compare, and turning the timer off during a pass, which separates the program continuing from the restart being suppressed.

// File: rtl/wkseq_pkg.sv
`timescale 1ns/1ps
package wkseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAKE, ST_SETTLE, ST_RUN, ST_PREP, ST_COUNT
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } seqStrobe_t;
endpackage

// File: rtl/wkseq_datapath.sv
`timescale 1ns/1ps
module wkseq_datapath
  import wkseq_pkg::*;
#(
  parameter int NUM_PERIODS = 5,
  parameter int IDX_W       = 3,
  parameter int PERIOD_W    = 16,
  parameter int PC_W        = 11,
  parameter int DEF_PERIOD  = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic                cfgWrEn,
  input  logic [IDX_W-1:0]    cfgWrIdx,
  input  logic [PERIOD_W-1:0] cfgWrData,
  input  logic                selReq,
  input  logic [IDX_W-1:0]    selIdx,
  input  logic                deepSleep,
  input  logic                runReq,
  input  logic [PC_W-1:0]     runEntry,
  input  logic                timerOffReq,
  output logic                countDone,
  output logic                timerEn,
  output logic [PC_W-1:0]     entryPc,
  output logic                cfgErr
);
  logic [PERIOD_W-1:0] periodReg [NUM_PERIODS];
  logic [PERIOD_W-1:0] periodSel;
  logic [PERIOD_W-1:0] cnt;
  logic [IDX_W-1:0]    selReg;

  for (genvar g = 0; g < NUM_PERIODS; g++) begin : gPeriod
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        periodReg[g] <= PERIOD_W'(DEF_PERIOD);
      else if (cfgWrEn && (int'(cfgWrIdx) == g))
        periodReg[g] <= cfgWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg  <= '0;
      cfgErr  <= 1'b0;
      timerEn <= 1'b0;
      entryPc <= '0;
      cnt     <= '0;
    end else begin
      if (selReq) begin
        if (deepSleep)
          selReg <= '0;
        else if (int'(selIdx) < NUM_PERIODS)
          selReg <= selIdx;
      end
      cfgErr <= cfgWrEn && (int'(cfgWrIdx) >= NUM_PERIODS);
      if (runReq) begin
        timerEn <= 1'b1;
        entryPc <= runEntry;
      end else if (timerOffReq) begin
        timerEn <= 1'b0;
      end
      if (strobe.cntClr)
        cnt <= '0;
      else if (strobe.cntInc)
        cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    periodSel = '0;
    for (int k = 0; k < NUM_PERIODS; k++)
      if (int'(selReg) == k) periodSel = periodReg[k];
  end

  assign countDone = (cnt >= periodSel);

  assert_sel_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    int'(selReg) < NUM_PERIODS);
  assert_deep_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (selReq && deepSleep) |=> (selReg == '0));
  assert_err_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> $past(cfgWrEn));
  assert_cnt_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> (cnt == '0));
endmodule

// File: rtl/wkseq_ctrl.sv
`timescale 1ns/1ps
module wkseq_ctrl
  import wkseq_pkg::*;
#(
  parameter int WAKE_CYC   = 2,
  parameter int SETTLE_CYC = 16,
  parameter int PREP_CYC   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runReq,
  input  logic       haltPulse,
  input  logic       timerEn,
  input  logic       countDone,
  output seqStrobe_t strobe,
  output logic       coreStart,
  output logic       busy
);
  localparam int MAX_A = (WAKE_CYC > PREP_CYC) ? WAKE_CYC : PREP_CYC;
  localparam int MAX_C = (SETTLE_CYC > MAX_A) ? SETTLE_CYC : MAX_A;
  localparam int PH_W  = $clog2(MAX_C + 1);

  seqState_t state, stateNxt;
  logic [PH_W-1:0] phase, phaseNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= '0;
    end else begin
      state <= stateNxt;
      phase <= phaseNxt;
    end
  end

  always_comb begin
    stateNxt  = state;
    phaseNxt  = phase;
    strobe    = '0;
    coreStart = 1'b0;
    unique case (state)
      ST_IDLE: if (runReq) begin
        stateNxt = ST_WAKE;
        phaseNxt = '0;
      end
      ST_WAKE: if (phase == PH_W'(WAKE_CYC - 1)) begin
        stateNxt = ST_SETTLE;
        phaseNxt = '0;
      end else phaseNxt = phase + 1'b1;
      ST_SETTLE: if (phase == PH_W'(SETTLE_CYC - 1)) begin
        stateNxt  = ST_RUN;
        coreStart = 1'b1;
      end else phaseNxt = phase + 1'b1;
      ST_RUN: if (haltPulse) begin
        stateNxt = ST_PREP;
        phaseNxt = '0;
      end
      ST_PREP: if (phase == PH_W'(PREP_CYC - 1)) begin
        if (timerEn) begin
          stateNxt      = ST_COUNT;
          strobe.cntClr = 1'b1;
        end else stateNxt = ST_IDLE;
      end else phaseNxt = phase + 1'b1;
      ST_COUNT: if (!timerEn) stateNxt = ST_IDLE;
      else if (countDone) begin
        stateNxt = ST_WAKE;
        phaseNxt = '0;
      end else strobe.cntInc = 1'b1;
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state == ST_WAKE) || (state == ST_SETTLE) ||
                (state == ST_RUN)  || (state == ST_PREP);

  assert_single_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    coreStart |=> !coreStart);
  assert_start_to_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    coreStart |=> (state == ST_RUN) && busy);
  assert_off_to_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COUNT) && !timerEn |=> (state == ST_IDLE));
  assert_busy_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COUNT) |-> !busy);
endmodule

// File: rtl/cop_wake_sequencer.sv
`timescale 1ns/1ps
module cop_wake_sequencer
  import wkseq_pkg::*;
#(
  parameter int NUM_PERIODS = 5,
  parameter int IDX_W       = 3,
  parameter int PERIOD_W    = 16,
  parameter int PC_W        = 11,
  parameter int DEF_PERIOD  = 100,
  parameter int WAKE_CYC    = 2,
  parameter int SETTLE_CYC  = 16,
  parameter int PREP_CYC    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [IDX_W-1:0]    cfgWrIdx,
  input  logic [PERIOD_W-1:0] cfgWrData,
  input  logic                runReq,
  input  logic [PC_W-1:0]     runEntry,
  input  logic                haltPulse,
  input  logic                selReq,
  input  logic [IDX_W-1:0]    selIdx,
  input  logic                timerOffReq,
  input  logic                deepSleep,
  output logic                coreStart,
  output logic [PC_W-1:0]     startPc,
  output logic                busy,
  output logic                cfgErr
);
  seqStrobe_t strobe;
  logic countDone;
  logic timerEn;

  wkseq_ctrl #(
    .WAKE_CYC(WAKE_CYC), .SETTLE_CYC(SETTLE_CYC), .PREP_CYC(PREP_CYC)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .runReq(runReq), .haltPulse(haltPulse),
    .timerEn(timerEn), .countDone(countDone), .strobe(strobe),
    .coreStart(coreStart), .busy(busy)
  );

  wkseq_datapath #(
    .NUM_PERIODS(NUM_PERIODS), .IDX_W(IDX_W), .PERIOD_W(PERIOD_W),
    .PC_W(PC_W), .DEF_PERIOD(DEF_PERIOD)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWrEn(cfgWrEn),
    .cfgWrIdx(cfgWrIdx), .cfgWrData(cfgWrData), .selReq(selReq),
    .selIdx(selIdx), .deepSleep(deepSleep), .runReq(runReq),
    .runEntry(runEntry), .timerOffReq(timerOffReq), .countDone(countDone),
    .timerEn(timerEn), .entryPc(startPc), .cfgErr(cfgErr)
  );
endmodule

// File: tb/test_cop_wake_sequencer.sv
`timescale 1ns/1ps
module test_cop_wake_sequencer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 0, runReq = 0, haltPulse = 0, selReq = 0, timerOffReq = 0, deepSleep = 0;
  logic [2:0]  cfgWrIdx = '0, selIdx = '0;
  logic [15:0] cfgWrData = '0;
  logic [10:0] runEntry = '0;
  logic coreStart, busy, cfgErr;
  logic [10:0] startPc;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cop_wake_sequencer #(.DEF_PERIOD(5)) i_cop_wake_sequencer (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx),
    .cfgWrData(cfgWrData), .runReq(runReq), .runEntry(runEntry),
    .haltPulse(haltPulse), .selReq(selReq), .selIdx(selIdx),
    .timerOffReq(timerOffReq), .deepSleep(deepSleep), .coreStart(coreStart),
    .startPc(startPc), .busy(busy), .cfgErr(cfgErr)
  );

  // {selIdx, deepSleep, expected halt-to-start latency}; periods 3,7,0,12,20
  localparam int VEC [6][3] = '{
    '{2, 0, 21}, '{4, 0, 41}, '{1, 1, 24}, '{3, 0, 33}, '{6, 0, 33}, '{1, 0, 28}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  // call at a negedge where a pulse was just raised; returns latency and pc
  task automatic waitStart(output int lat, output logic [10:0] pc);
    @(negedge clk);
    haltPulse = 0; runReq = 0; selReq = 0; timerOffReq = 0; cfgWrEn = 0;
    lat = 1;
    while (!coreStart && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
    pc = startPc;
    @(negedge clk);
    chk("R11 start pulse width", {31'b0, coreStart}, 32'd0);
    chk("R10 busy while running", {31'b0, busy}, 32'd1);
  endtask

  task automatic selCmd(int idx, bit deep);
    selReq = 1; selIdx = 3'(idx); deepSleep = deep;
    @(negedge clk);
    selReq = 0; deepSleep = 0;
  endtask

  task automatic cfgWrite(int idx, int data);
    cfgWrEn = 1; cfgWrIdx = 3'(idx); cfgWrData = 16'(data);
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int lat;
    logic [10:0] pc;
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy after reset", {31'b0, busy}, 32'd0);
    chk("R1 coreStart after reset", {31'b0, coreStart}, 32'd0);
    chk("R1 cfgErr after reset", {31'b0, cfgErr}, 32'd0);

    // R6 program periods; bad index raises flag for one cycle
    cfgWrite(0, 3); cfgWrite(1, 7); cfgWrite(2, 0); cfgWrite(3, 12); cfgWrite(4, 20);
    cfgWrite(5, 1);
    chk("R6 cfgErr after bad index", {31'b0, cfgErr}, 32'd1);
    @(negedge clk);
    chk("R6 cfgErr single cycle", {31'b0, cfgErr}, 32'd0);
    chk("R1 timer disabled, still idle", {31'b0, busy}, 32'd0);

    // R2 run from idle
    runReq = 1; runEntry = 11'h123;
    waitStart(lat, pc);
    chk("R2 run latency", lat, 18);
    chk("R2 start pc", {21'b0, pc}, 32'h123);

    // R1/R3 default selection index 0 (period 3); R10 busy low while counting
    haltPulse = 1;
    @(negedge clk); haltPulse = 0;
    chk("R10 busy in prepare", {31'b0, busy}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R10 busy low while counting", {31'b0, busy}, 32'd0);
    lat = 4;
    while (!coreStart && lat < 3000) begin @(negedge clk); lat++; end
    chk("R1 R3 index 0 latency", lat, 24);
    @(negedge clk);

    // R3 R4 R5 R6 table of selections
    for (int i = 0; i < 6; i++) begin
      selCmd(VEC[i][0], VEC[i][1] != 0);
      haltPulse = 1;
      waitStart(lat, pc);
      chk($sformatf("R3 R4 R5 R6 vector %0d latency", i), lat, VEC[i][2]);
      chk("R3 restart pc", {21'b0, pc}, 32'h123);
    end

    // R8 run while not idle replaces entry
    runReq = 1; runEntry = 11'h2AB;
    @(negedge clk); runReq = 0;
    chk("R8 sequence undisturbed", {31'b0, busy}, 32'd1);
    selCmd(2, 0);
    haltPulse = 1;
    waitStart(lat, pc);
    chk("R8 latency", lat, 21);
    chk("R8 new entry", {21'b0, pc}, 32'h2AB);

    // R9 lower period mid-count
    selCmd(4, 0);
    haltPulse = 1;
    @(negedge clk); haltPulse = 0;
    n = 1;
    while (!coreStart && n < 3000) begin
      if (n == 12) begin cfgWrEn = 1; cfgWrIdx = 3'd4; cfgWrData = 16'd2; end
      @(negedge clk);
      cfgWrEn = 0;
      n++;
    end
    chk("R9 lowered period latency", n, 31);
    @(negedge clk);

    // R7 timer off: program continues, no restart afterwards
    timerOffReq = 1;
    @(negedge clk); timerOffReq = 0;
    chk("R7 program keeps running", {31'b0, busy}, 32'd1);
    haltPulse = 1;
    @(negedge clk); haltPulse = 0;
    seen = 0;
    repeat (60) begin
      if (coreStart) seen = 1;
      @(negedge clk);
    end
    chk("R7 no restart after off", {31'b0, seen}, 32'd0);
    chk("R7 R10 idle busy low", {31'b0, busy}, 32'd0);
    runReq = 1; runEntry = 11'h055;
    waitStart(lat, pc);
    chk("R7 new run latency", lat, 18);
    chk("R7 new run pc", {21'b0, pc}, 32'h055);

    report();
  end
endmodule